// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 external interrupt lines for a small processor core. It decides which of them the core should service next. Each line has an enable bit, a pending bit and a two-bit priority value, all of which software can program through a small word-addressed register bus. Enable and pending are each changed through a pair of registers, one for setting bits and one for clearing them. Writing a one acts on a bit and writing a zero leaves it alone, so a write never needs to read the register first.

Every line keeps its own state: idle, pending, active, or pending and active. A rising edge on a line, or a software set, makes the line pending. The controller picks the best enabled pending line and checks whether it may interrupt the handler now running. If it may, the controller raises a request. The request carries the exception number (line index plus 16) and the address of the vector-table word for that exception.

The core accepts a request with a take pulse and reports the end of its current handler with a done pulse. Another line may be eligible at the moment a handler ends. In that case the request that follows is flagged as a tail-chained handoff, which tells the core to go straight to the next handler without unstacking and restacking its registers.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset, every enable, pending, active and priority bit is zero, all readable registers return 0, and irq_req and irq_tail are low.
- R2: A write to word 0 (byte address 0x00) sets every enable bit written as 1. A write to word 1 (0x04) clears every enable bit written as 1. Bits written as 0 are unchanged in both cases. Reading either address returns the enable bits.
- R3: A write to word 2 (0x08) makes pending every line whose bit is written as 1. A write to word 3 (0x0C) removes the pending state of every line whose bit is written as 1. Bits written as 0 have no effect. Reading either address returns the pending bits.
- R4: A 0-to-1 transition on irq_line[n] makes line n pending, and the pending bit is readable one clock edge later. A line that stays high does not become pending again after it has been taken.
- R5: Priority words sit at byte addresses 0x20 + 4k for k = 0 to 7. Line 4k+j keeps its priority in bits [8j+1:8j] of word k. All other bits of these words read as zero.
- R6: Only lines that are both pending and enabled take part in arbitration. Among them, the lowest priority value wins. When priority values are equal, the lower line index wins.
- R7: While irq_req is high, irq_excnum carries the winning line index plus 16. At the same time, irq_vector carries VEC_BASE + 4 × irq_excnum.
- R8: A take pulse while irq_req is high clears the pending state of the presented line and makes it active. A new edge on that line while its handler runs leaves it pending and active.
- R9: While a handler is active, irq_req is raised only for a candidate whose priority value is strictly lower than that handler's. Otherwise the candidate stays pending.
- R10: A done pulse ends the active handler with the lowest priority value. Any handler it had interrupted becomes the running one again and keeps blocking candidates that do not beat its priority.
- R11: A candidate may be eligible to take over in the cycle a done pulse arrives. If so, from the next cycle on, irq_tail is high together with irq_req until the take. A request that arises at any other time has irq_tail low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | 32 | Interrupt lines, one per source, rising edge sets pending |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| core_take | input | 1 | Core accepts the presented interrupt |
| core_done | input | 1 | Core finished the current handler |
| irq_req | output | 1 | An interrupt is presented to the core |
| irq_excnum | output | 6 | Exception number of the presented interrupt |
| irq_vector | output | 32 | Vector-table word address for that exception |
| irq_tail | output | 1 | Presented interrupt is a tail-chained handoff |

## Verification
The bench builds the controller with its default 32 lines and 2-bit priorities, so that line 31 and the highest priority word (0x3C) are reached. It sets VEC_BASE to 0x4000, so that the base is visibly added to the exception offset. With four priority levels the bench can set up equal-priority ties, two-deep nesting in which an inner handler ends and the outer one blocks a same-level candidate, and a handler re-firing on its own line, all with few register writes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int DATA_W       = 32;
    localparam int EXC_BASE     = 16;
    localparam int PRIO_PER_REG = 4;
    localparam int FIELD_STRIDE = 8;

    // word indices on the register bus
    localparam int WIDX_ENA_SET = 0;
    localparam int WIDX_ENA_CLR = 1;
    localparam int WIDX_PND_SET = 2;
    localparam int WIDX_PND_CLR = 3;
    localparam int WIDX_PRIO0   = 8;

    // {active, pending}
    typedef enum logic [1:0] {
        SRC_IDLE     = 2'b00,
        SRC_PEND     = 2'b01,
        SRC_ACT      = 2'b10,
        SRC_PEND_ACT = 2'b11
    } src_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] pnd_set;
        logic [DATA_W-1:0] pnd_clr;
    } sw_pend_cmd_t;

    function automatic logic [DATA_W-1:0] vec_addr(input logic [DATA_W-1:0] base,
                                                   input logic [DATA_W-1:0] exc);
        return base + (exc << 2);
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic take,
    input  logic done,
    output logic pend,
    output logic act
);

    logic       line_q;
    logic       edge_seen;
    src_state_e state_q, state_d;
    logic       p_n, a_n;

    assign edge_seen = line_in & ~line_q;
    assign pend      = state_q[0];
    assign act       = state_q[1];

    always_comb begin
        p_n     = (pend & ~sw_clr & ~take) | edge_seen | sw_set;
        a_n     = (act & ~done) | take;
        state_d = src_state_e'({a_n, p_n});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b0;
            state_q <= SRC_IDLE;
        end else begin
            line_q  <= line_in;
            state_q <= state_d;
        end
    end

    AST_TAKE_ONLY_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
        take |-> (state_q == SRC_PEND)) else $error("take on non-pending source"); // R8
    AST_TAKE_MAKES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        take |=> act) else $error("take did not activate source"); // R8
    AST_DONE_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (done && !take) |=> !act) else $error("done left source active"); // R10
    AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> pend) else $error("edge did not set pending"); // R4

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N   = 32,
    parameter int PW  = 2,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 win_valid,
    output logic [IDW-1:0]       win_id,
    output logic [PW-1:0]        win_prio
);

    // lowest value wins; strict compare keeps the lower index on ties
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!win_valid || (prio[i] < win_prio))) begin
                win_valid = 1'b1;
                win_id    = IDW'(i);
                win_prio  = prio[i];
            end
        end
    end

    always_comb begin
        if (win_valid) begin
            AST_WIN_IS_CANDIDATE: assert (cand[win_id]) else $error("winner not a candidate"); // R6
        end
    end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_ctrl_pkg::*;
#(
    parameter int N      = 32,
    parameter int PW     = 2,
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [N-1:0]         pend_vec,
    output logic [N-1:0]         ena_vec,
    output logic [N-1:0][PW-1:0] prio_arr,
    output sw_pend_cmd_t         sw_cmd
);

    localparam int WIW = ADDR_W - 2;
    localparam int NPR = N / PRIO_PER_REG;

    logic [WIW-1:0]        widx;
    logic                  aligned;
    logic                  wr;
    logic                  wr_ena_set, wr_ena_clr;
    logic [N-1:0]          ena_q;
    logic [N-1:0][PW-1:0]  prio_q;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign wr         = bus_en & bus_we & aligned;
    assign wr_ena_set = wr && (widx == WIW'(WIDX_ENA_SET));
    assign wr_ena_clr = wr && (widx == WIW'(WIDX_ENA_CLR));
    assign ena_vec    = ena_q;
    assign prio_arr   = prio_q;

    always_comb begin
        sw_cmd = '0;
        if (wr && (widx == WIW'(WIDX_PND_SET))) sw_cmd.pnd_set = bus_wdata;
        if (wr && (widx == WIW'(WIDX_PND_CLR))) sw_cmd.pnd_clr = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q  <= '0;
            prio_q <= '0;
        end else begin
            if (wr_ena_set) ena_q <= ena_q | bus_wdata[N-1:0];
            if (wr_ena_clr) ena_q <= ena_q & ~bus_wdata[N-1:0];
            for (int k = 0; k < NPR; k++) begin
                if (wr && (widx == WIW'(WIDX_PRIO0 + k))) begin
                    for (int j = 0; j < PRIO_PER_REG; j++) begin
                        prio_q[k*PRIO_PER_REG + j] <= bus_wdata[j*FIELD_STRIDE +: PW];
                    end
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if ((widx == WIW'(WIDX_ENA_SET)) || (widx == WIW'(WIDX_ENA_CLR)))
                bus_rdata[N-1:0] = ena_q;
            if ((widx == WIW'(WIDX_PND_SET)) || (widx == WIW'(WIDX_PND_CLR)))
                bus_rdata[N-1:0] = pend_vec;
            for (int k = 0; k < NPR; k++) begin
                if (widx == WIW'(WIDX_PRIO0 + k)) begin
                    for (int j = 0; j < PRIO_PER_REG; j++) begin
                        bus_rdata[j*FIELD_STRIDE +: PW] = prio_q[k*PRIO_PER_REG + j];
                    end
                end
            end
        end
    end

    AST_ENA_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_ena_set |=> ((ena_q & $past(ena_q)) == $past(ena_q))) else $error("enable set lost a bit"); // R2
    AST_ENA_CLR_NO_SET: assert property (@(posedge clk) disable iff (rst)
        wr_ena_clr |=> ((ena_q & ~$past(ena_q)) == '0)) else $error("enable clear added a bit"); // R2

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int          NUM_IRQ  = 32,
    parameter int          PRIO_W   = 2,
    parameter int          ADDR_W   = 6,
    parameter logic [31:0] VEC_BASE = 32'h0000_0000,
    localparam int         IDW      = $clog2(NUM_IRQ),
    localparam int         EXC_W    = $clog2(NUM_IRQ + EXC_BASE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               core_take,
    input  logic               core_done,
    output logic               irq_req,
    output logic [EXC_W-1:0]   irq_excnum,
    output logic [31:0]        irq_vector,
    output logic               irq_tail
);

    logic [NUM_IRQ-1:0]             pend_vec, act_vec, ena_vec;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_arr;
    sw_pend_cmd_t                   sw_cmd;
    logic [NUM_IRQ-1:0]             take_vec, done_vec, act_after;

    logic              best_valid, cur_valid, aft_valid;
    logic [IDW-1:0]    best_id, cur_id, aft_id;
    logic [PRIO_W-1:0] best_prio, cur_prio, aft_prio;
    logic              chain_ok;
    logic              tail_q;

    irq_regfile #(.N(NUM_IRQ), .PW(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_vec(pend_vec), .ena_vec(ena_vec), .prio_arr(prio_arr),
        .sw_cmd(sw_cmd)
    );

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        irq_src_cell u_cell (
            .clk(clk), .rst(rst),
            .line_in(irq_line[g]),
            .sw_set(sw_cmd.pnd_set[g]),
            .sw_clr(sw_cmd.pnd_clr[g]),
            .take(take_vec[g]),
            .done(done_vec[g]),
            .pend(pend_vec[g]),
            .act(act_vec[g])
        );
    end

    // best pending candidate
    irq_pick #(.N(NUM_IRQ), .PW(PRIO_W), .IDW(IDW)) u_pick_pend (
        .cand(pend_vec & ena_vec), .prio(prio_arr),
        .win_valid(best_valid), .win_id(best_id), .win_prio(best_prio)
    );

    // running handler: lowest value among active sources
    irq_pick #(.N(NUM_IRQ), .PW(PRIO_W), .IDW(IDW)) u_pick_act (
        .cand(act_vec), .prio(prio_arr),
        .win_valid(cur_valid), .win_id(cur_id), .win_prio(cur_prio)
    );

    // handler left running once the current one completes
    irq_pick #(.N(NUM_IRQ), .PW(PRIO_W), .IDW(IDW)) u_pick_after (
        .cand(act_after), .prio(prio_arr),
        .win_valid(aft_valid), .win_id(aft_id), .win_prio(aft_prio)
    );

    assign irq_req = best_valid && (!cur_valid || (best_prio < cur_prio));

    always_comb begin
        take_vec = '0;
        done_vec = '0;
        if (core_take && irq_req) take_vec[best_id] = 1'b1;
        if (core_done && cur_valid) done_vec[cur_id] = 1'b1;
        act_after = act_vec & ~done_vec;
    end

    assign chain_ok = core_done && cur_valid && best_valid &&
                      (!aft_valid || (best_prio < aft_prio));

    always_ff @(posedge clk) begin
        if (rst)            tail_q <= 1'b0;
        else if (core_take) tail_q <= 1'b0;
        else if (chain_ok)  tail_q <= 1'b1;
        else if (!irq_req)  tail_q <= 1'b0;
    end

    assign irq_tail   = tail_q & irq_req;
    assign irq_excnum = irq_req ? (EXC_W'(best_id) + EXC_W'(EXC_BASE)) : '0;
    assign irq_vector = irq_req ? vec_addr(VEC_BASE, 32'(irq_excnum)) : '0;

    AST_TAIL_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_tail) |-> $past(core_done)) else $error("tail flag without done"); // R11
    AST_TAKEN_BECOMES_CURRENT: assert property (@(posedge clk) disable iff (rst)
        (core_take && irq_req && !core_done) |=> (cur_valid && (cur_id == $past(best_id))))
        else $error("taken source is not the running handler"); // R9

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam logic [31:0] BASE = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_line = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_take = 1'b0, core_done = 1'b0;
    logic        irq_req, irq_tail;
    logic [5:0]  irq_excnum;
    logic [31:0] irq_vector;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl #(.VEC_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .irq_line(irq_line),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_take(core_take), .core_done(core_done),
        .irq_req(irq_req), .irq_excnum(irq_excnum),
        .irq_vector(irq_vector), .irq_tail(irq_tail)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic pulse_take();
        @(negedge clk); core_take = 1'b1;
        @(negedge clk); core_take = 1'b0;
        #1;
    endtask

    task automatic pulse_done();
        @(negedge clk); core_done = 1'b1;
        @(negedge clk); core_done = 1'b0;
        #1;
    endtask

    task automatic drive_line(input int n, input logic v);
        @(negedge clk); irq_line[n] = v;
        @(negedge clk);
        #1;
    endtask

    task automatic set_prio(input int n, input logic [1:0] p);
        logic [31:0] w;
        logic [5:0]  a;
        a = 6'(32 + 4 * (n / 4));
        rd(a, w);
        w[8 * (n % 4) +: 2] = p;
        wr(a, w);
    endtask

    task automatic clean();
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rd(6'h00, v); check("R1 enable after reset", v, 0);
        rd(6'h0C, v); check("R1 pending after reset", v, 0);
        rd(6'h20, v); check("R1 prio word0 after reset", v, 0);
        rd(6'h3C, v); check("R1 prio word7 after reset", v, 0);
        check("R1 irq_req after reset", irq_req, 0);
        check("R1 irq_tail after reset", irq_tail, 0);
    endtask

    task automatic test_enable();
        logic [31:0] v;
        wr(6'h00, 32'h0000_00F5);
        rd(6'h00, v); check("R2 set-enable", v, 32'hF5);
        wr(6'h00, 32'h0);
        rd(6'h00, v); check("R2 zero write to set-enable", v, 32'hF5);
        wr(6'h04, 32'h0000_0005);
        rd(6'h04, v); check("R2 clear-enable readback", v, 32'hF0);
        wr(6'h04, 32'h0);
        rd(6'h00, v); check("R2 zero write to clear-enable", v, 32'hF0);
        clean();
    endtask

    task automatic test_prio();
        logic [31:0] v;
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h20, v); check("R5 unused priority bits read zero", v, 32'h0303_0303);
        wr(6'h3C, 32'h0201_0300);
        rd(6'h3C, v); check("R5 top priority word fields", v, 32'h0201_0300);
        wr(6'h20, 32'h0);
        wr(6'h3C, 32'h0);
    endtask

    task automatic test_sw_pend();
        logic [31:0] v;
        wr(6'h08, 32'h0000_0008);
        rd(6'h08, v); check("R3 set-pending readback", v, 32'h8);
        rd(6'h0C, v); check("R3 clear-pending address reads pending", v, 32'h8);
        check("R6 disabled pending gives no request", irq_req, 0);
        wr(6'h08, 32'h0);
        rd(6'h08, v); check("R3 zero write keeps pending", v, 32'h8);
        wr(6'h00, 32'h0000_0008);
        check("R6 enabled pending requests", irq_req, 1);
        check("R7 exception number line3", irq_excnum, 19);
        check("R7 vector address line3", irq_vector, BASE + 32'd76);
        check("R11 plain request has no tail flag", irq_tail, 0);
        wr(6'h0C, 32'h0000_0008);
        rd(6'h08, v); check("R3 clear-pending", v, 32'h0);
        check("R3 request drops after clear", irq_req, 0);
        clean();
    endtask

    task automatic test_arb();
        set_prio(5, 2); set_prio(9, 1); set_prio(12, 1);
        wr(6'h00, 32'h0000_1220);
        wr(6'h08, 32'h0000_1220);
        check("R6 lowest value and tie to lower index", irq_excnum, 25);
        wr(6'h0C, 32'h0000_0200);
        check("R6 next best after clearing line9", irq_excnum, 28);
        wr(6'h0C, 32'h0000_1000);
        check("R6 remaining lowest priority", irq_excnum, 21);
        wr(6'h00, 32'h8000_0000);
        wr(6'h08, 32'h8000_0000);
        check("R6 line31 prio0 beats line5 prio2", irq_excnum, 47);
        check("R7 vector for line31", irq_vector, BASE + 32'd188);
        clean();
        check("R6 no request after clearing", irq_req, 0);
        set_prio(5, 0); set_prio(9, 0); set_prio(12, 0);
    endtask

    task automatic test_edge_tail();
        logic [31:0] v;
        set_prio(7, 1);
        wr(6'h00, 32'h0000_0080);
        drive_line(7, 1'b1);
        rd(6'h08, v); check("R4 rising edge sets pending", v, 32'h80);
        check("R7 exception number line7", irq_excnum, 23);
        pulse_take();
        check("R8 take drops request", irq_req, 0);
        rd(6'h08, v); check("R8 take clears pending", v, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        rd(6'h08, v); check("R4 held line does not re-pend", v, 32'h0);
        drive_line(7, 1'b0);
        drive_line(7, 1'b1);
        rd(6'h08, v); check("R8 re-fire leaves pending and active", v, 32'h80);
        check("R9 equal priority does not preempt", irq_req, 0);
        pulse_done();
        check("R11 handoff request after done", irq_req, 1);
        check("R11 tail flag on handoff", irq_tail, 1);
        check("R11 handoff exception number", irq_excnum, 23);
        pulse_take();
        check("R11 tail flag cleared by take", irq_tail, 0);
        pulse_done();
        check("R11 no request when nothing pending", irq_req, 0);
        check("R11 no tail when nothing pending", irq_tail, 0);
        drive_line(7, 1'b0);
        clean();
        set_prio(7, 0);
    endtask

    task automatic test_preempt();
        set_prio(2, 2); set_prio(4, 2); set_prio(6, 1);
        wr(6'h00, 32'h0000_0054);
        wr(6'h08, 32'h0000_0004);
        check("R6 line2 requested", irq_excnum, 18);
        pulse_take();
        wr(6'h08, 32'h0000_0010);
        check("R9 equal priority waits", irq_req, 0);
        wr(6'h08, 32'h0000_0040);
        check("R9 strictly lower value preempts", irq_req, 1);
        check("R9 preempting exception number", irq_excnum, 22);
        pulse_take();
        check("R8 nested take drops request", irq_req, 0);
        pulse_done();
        check("R10 outer handler still blocks line4", irq_req, 0);
        check("R11 no tail while blocked", irq_tail, 0);
        pulse_done();
        check("R11 chained line4 after outer done", irq_excnum, 20);
        check("R11 tail flag for line4", irq_tail, 1);
        pulse_take();
        pulse_done();
        check("R10 all handlers finished", irq_req, 0);
        clean();
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        test_reset();
        test_enable();
        test_prio();
        test_sw_pend();
        test_arb();
        test_edge_tail();
        test_preempt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule